// File: doc/BRIEF.md
# Streaming ShiftRows Byte Permuter

This block reorders an AES State that arrives one byte per clock so that the bytes leave in the order the ShiftRows step produces. Bytes travel in column-major order, so the byte at position `4*col + row` is the byte of that row and column. The row at index 0 keeps its place. Rows 1, 2 and 3 rotate left by one, two and three columns. The block does no substitution, no column mixing and no key addition. It only holds and moves bytes, so it sits on a byte-wide loop-back cipher datapath between the key XOR and the substitution stage.

Storage is exactly twelve byte registers. Each register belongs to one of seven short lanes. A free-running 4-bit phase counter restarts on the block marker and selects, in every cycle, the one lane that is read and rewritten, or selects a straight bypass from input to output. The first output byte of a block appears twelve cycles after its first input byte. Blocks can follow one another with no idle cycle. A block can also start after an idle stretch, provided the previous block has fully left.

Top module: `shiftRowsStream`

## Requirements
- R1: Output byte `k = 4*c + r` of a block (`c` the column, `r` the row, both 0 to 3) equals input byte `4*((c + r) mod 4) + r` of the same block. Both streams are in column-major order, byte 0 first.
- R2: Output byte k of a block is presented exactly 12 cycles after input byte k of that block would have entered. In particular, the first output byte appears 12 cycles after the first input byte, and every row-0 byte leaves exactly 12 cycles after it entered.
- R3: `outValid` in any cycle equals `inValid` twelve cycles earlier.
- R4: A new block whose first byte, with `inFirst` high, arrives in the cycle right after the sixteenth byte of the previous block is permuted correctly, and so is the previous block. No idle cycle is needed between blocks.
- R5: When no output is pending, a block that starts after an idle gap of any length (including lengths that are not multiples of 16) is permuted correctly, because `inFirst` with `inValid` restarts the phase at 0.
- R6: A synchronous reset clears the stored bytes and the phase. In the first cycle after reset, with inputs idle, `outValid` is 0 and `outByte` is 0.
- R7: The last input byte of a block (position 15) appears on `outByte` in the same cycle it is presented, as output byte 3 of that block.
- R8: A byte or marker presented while `inValid` is 0 never shows up on `outByte` in a cycle where `outValid` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input byte strobe |
| inFirst | input | 1 | Marks byte 0 of a block; used only together with inValid |
| inByte | input | BYTE_W | Input byte, column-major order |
| outValid | output | 1 | Output byte strobe, inValid delayed by 12 cycles |
| outByte | output | BYTE_W | Permuted output byte |

## Verification
The delay properties assume that every block is 16 consecutive valid bytes and that `inFirst` is raised only on byte 0. They also assume that a new block begins either right after the previous block's last byte or at least twelve idle cycles later, so no row of an earlier block is still waiting when the phase restarts. The stimulus keeps to these rules. It sends back-to-back runs and single blocks separated by 13-, 14- and 21-cycle gaps. During the gaps it drives random bytes and stray markers with the strobe low, which probes the claim that such inputs never surface.

// File: rtl/shiftRowsPkg.sv
package shiftRowsPkg;

  // AES State geometry and streaming timing.
  localparam int BLOCK_BYTES = 16;
  localparam int ROWS        = 4;
  localparam int PHASE_W     = $clog2(BLOCK_BYTES);
  localparam int LATENCY     = 12;
  localparam int NUM_LANES   = 7;
  localparam int LANE_IDX_W  = $clog2(NUM_LANES + 1);

  // Lanes group the bytes whose storage intervals chain into one another.
  typedef enum logic [LANE_IDX_W-1:0] {
    LANE_ROW0   = 3'd0,  // bytes 0,4,8,12: three deep, first in first out
    LANE_ROW1L  = 3'd1,  // bytes 1,9: two deep
    LANE_ROW2   = 3'd2,  // bytes 2,6,10,14: three deep
    LANE_ROW1S  = 3'd3,  // bytes 5,13: one deep
    LANE_R3A    = 3'd4,  // byte 3
    LANE_R3B    = 3'd5,  // byte 7
    LANE_R3C    = 3'd6,  // byte 11
    LANE_NONE   = 3'd7   // byte 15 goes straight through
  } laneId_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic [NUM_LANES-1:0] laneWr;   // one-hot: lane read and rewritten this cycle
    logic                 shift;    // advance the selected lane's chain
    logic                 readTail; // take the oldest entry instead of the head
    logic                 bypass;   // pass the input byte straight out
  } srCtrl_t;

  typedef struct packed {
    laneId_t lane;
    logic    shift;
    logic    readTail;
  } phaseCode_t;

  function automatic int laneDepth(input int lane);
    case (lane)
      0:       return 3;
      1:       return 2;
      2:       return 3;
      default: return 1;
    endcase
  endfunction

  // Phase p is the block position of the byte at the input in this cycle.
  // The byte read out in the same cycle is output position (p+4) mod 16.
  function automatic phaseCode_t decodePhase(input logic [PHASE_W-1:0] p);
    phaseCode_t c;
    c.shift    = 1'b1;
    c.readTail = 1'b1;
    c.lane     = LANE_NONE;
    if (p[1:0] == 2'd0) begin
      c.lane = LANE_ROW0;
    end else begin
      case (p)
        4'd1:  begin c.lane = LANE_ROW1L; c.shift = 1'b0; c.readTail = 1'b0; end
        4'd9:  c.lane = LANE_ROW1L;
        4'd2:  begin c.lane = LANE_ROW2;  c.shift = 1'b0; c.readTail = 1'b0; end
        4'd14: begin c.lane = LANE_ROW2;  c.shift = 1'b0; c.readTail = 1'b0; end
        4'd6:  c.lane = LANE_ROW2;
        4'd10: c.lane = LANE_ROW2;
        4'd5:  c.lane = LANE_ROW1S;
        4'd13: c.lane = LANE_ROW1S;
        4'd3:  c.lane = LANE_R3A;
        4'd7:  c.lane = LANE_R3B;
        4'd11: c.lane = LANE_R3C;
        default: c.lane = LANE_NONE;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/srLane.sv
module srLane #(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              shift,
  input  logic              readTail,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout
);

  logic [BYTE_W-1:0] chain [DEPTH];

  // A write always lands at the head. With shift set, every entry moves one
  // step toward the tail and the tail entry, already read, is dropped.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) chain[i] <= '0;
    end else if (wr) begin
      chain[0] <= din;
      if (shift) begin
        for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
      end
    end
  end

  assign dout = readTail ? chain[DEPTH-1] : chain[0];

endmodule

// File: rtl/srControl.sv
module srControl
  import shiftRowsPkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  input  logic    inFirst,
  output srCtrl_t ctrl,
  output logic    outValid
);

  logic [PHASE_W-1:0] phaseQ;
  logic [PHASE_W-1:0] phaseNow;
  logic [LATENCY-1:0] validPipe;
  phaseCode_t         code;

  // The marker forces phase 0 in its own cycle; otherwise the count runs on.
  assign phaseNow = (inFirst && inValid) ? '0 : phaseQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ    <= '0;
      validPipe <= '0;
    end else begin
      phaseQ    <= phaseNow + PHASE_W'(1);
      validPipe <= {validPipe[LATENCY-2:0], inValid};
    end
  end

  always_comb begin
    code          = decodePhase(phaseNow);
    ctrl          = '0;
    ctrl.bypass   = (code.lane == LANE_NONE);
    ctrl.shift    = code.shift;
    ctrl.readTail = code.readTail;
    if (code.lane != LANE_NONE) ctrl.laneWr[code.lane] = 1'b1;
  end

  assign outValid = validPipe[LATENCY-1];

endmodule

// File: rtl/srDatapath.sv
module srDatapath
  import shiftRowsPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  srCtrl_t           ctrl,
  input  logic [BYTE_W-1:0] inByte,
  output logic [BYTE_W-1:0] outByte
);

  logic [BYTE_W-1:0] laneOut [NUM_LANES];
  logic [BYTE_W-1:0] picked;

  for (genvar l = 0; l < NUM_LANES; l++) begin : gLane
    srLane #(
      .BYTE_W (BYTE_W),
      .DEPTH  (laneDepth(l))
    ) uLane (
      .clk      (clk),
      .rst      (rst),
      .wr       (ctrl.laneWr[l]),
      .shift    (ctrl.shift),
      .readTail (ctrl.readTail),
      .din      (inByte),
      .dout     (laneOut[l])
    );
  end

  // The lane that is rewritten is also the lane that is read, so the
  // one-hot write strobes double as the output select.
  always_comb begin
    picked = '0;
    for (int l = 0; l < NUM_LANES; l++) begin
      if (ctrl.laneWr[l]) picked = picked | laneOut[l];
    end
    outByte = ctrl.bypass ? inByte : picked;
  end

endmodule

// File: rtl/shiftRowsStream.sv
module shiftRowsStream
  import shiftRowsPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              inFirst,
  input  logic [BYTE_W-1:0] inByte,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte
);

  srCtrl_t ctrl;

  srControl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inFirst  (inFirst),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  srDatapath #(.BYTE_W(BYTE_W)) uPath (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .inByte  (inByte),
    .outByte (outByte)
  );

endmodule

// File: rtl/srStreamCheck.sv
module srStreamCheck #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inFirst,
  input logic [BYTE_W-1:0] inByte,
  input logic              outValid,
  input logic [BYTE_W-1:0] outByte
);

  logic [4:0] sinceRst;
  logic [3:0] posCnt;
  logic [3:0] curPos;

  // Own block-position tracker, independent of the design's phase.
  assign curPos = (inValid && inFirst) ? 4'd0 : posCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceRst <= '0;
      posCnt   <= '0;
    end else begin
      if (sinceRst != 5'd31) sinceRst <= sinceRst + 5'd1;
      if (inValid) posCnt <= curPos + 4'd1;
    end
  end

  assert_reset_idle_R6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !outValid);

  assert_valid_delay_R3: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 5'd12) |-> (outValid == $past(inValid, 12)));

  assert_row0_delay_R2: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 5'd12 && $past(inValid, 12) && $past(curPos[1:0], 12) == 2'd0)
      |-> (outByte == $past(inByte, 12)));

  assert_last_bypass_R7: assert property (@(posedge clk) disable iff (rst)
    (inValid && curPos == 4'd15) |-> (outValid && outByte == inByte));

  // R1: row 1, columns 1..3 leave eight cycles after entry.
  assert_row1_short_R1: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 5'd8 && $past(inValid, 8) &&
     ($past(curPos, 8) == 4'd5 || $past(curPos, 8) == 4'd9 || $past(curPos, 8) == 4'd13))
      |-> (outByte == $past(inByte, 8)));

  // R1: row 1, column 0 wraps to the last column.
  assert_row1_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 5'd24 && $past(inValid, 24) && $past(curPos, 24) == 4'd1)
      |-> (outByte == $past(inByte, 24)));

  assert_row2_short_R1: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 5'd4 && $past(inValid, 4) &&
     ($past(curPos, 4) == 4'd10 || $past(curPos, 4) == 4'd14))
      |-> (outByte == $past(inByte, 4)));

  assert_row2_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 5'd20 && $past(inValid, 20) &&
     ($past(curPos, 20) == 4'd2 || $past(curPos, 20) == 4'd6))
      |-> (outByte == $past(inByte, 20)));

  assert_row3_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 5'd16 && $past(inValid, 16) &&
     ($past(curPos, 16) == 4'd3 || $past(curPos, 16) == 4'd7 || $past(curPos, 16) == 4'd11))
      |-> (outByte == $past(inByte, 16)));

endmodule

bind shiftRowsStream srStreamCheck #(.BYTE_W(BYTE_W)) uCheck (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inFirst  (inFirst),
  .inByte   (inByte),
  .outValid (outValid),
  .outByte  (outByte)
);

// File: tb/tb_shiftRowsStream.sv
`timescale 1ns/1ps
module tb_shiftRowsStream;

  localparam int LAT = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rstNext = 1'b1;
  logic       inValid = 1'b0;
  logic       inFirst = 1'b0;
  logic [7:0] inByte = '0;
  logic       outValid;
  logic [7:0] outByte;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    blkStart = 0;
  int    blkPos = 0;
  bit    done = 0;
  string tag = "R6";

  logic [7:0] expByte [int];
  string      expTag  [int];
  logic [7:0] blkBuf  [16];

  always #2 clk = ~clk;

  shiftRowsStream dut (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inFirst  (inFirst),
    .inByte   (inByte),
    .outValid (outValid),
    .outByte  (outByte)
  );

  // Output position of input byte j under the rotation rule.
  function automatic int destOf(input int j);
    int c = j / 4;
    int r = j % 4;
    return 4 * ((c - r + 4) % 4) + r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic tick(input bit v, input bit f, input logic [7:0] b);
    int k;
    @(negedge clk);
    rst     = rstNext;
    inValid = v;
    inFirst = f;
    inByte  = b;
    if (v) begin
      if (f) begin
        blkStart = cyc;
        blkPos   = 0;
      end
      k = destOf(blkPos);
      expByte[blkStart + LAT + k] = b;
      expTag[blkStart + LAT + k]  = (k % 4 == 0) ? "R2" : "R1";
      blkPos++;
    end
    #1;
    if (!rst) begin
      if (expByte.exists(cyc)) begin
        check(outValid == 1'b1, {tag, "/R3"}, "outValid", outValid, 1);
        check(outByte == expByte[cyc], {tag, "/", expTag[cyc]}, "outByte",
              outByte, expByte[cyc]);
        expByte.delete(cyc);
        expTag.delete(cyc);
      end else begin
        check(outValid == 1'b0, {tag, "/R3/R8"}, "outValid idle", outValid, 0);
      end
    end
    cyc++;
  endtask

  task automatic sendBlock();
    for (int i = 0; i < 16; i++) begin
      tick(1'b1, i == 0, blkBuf[i]);
      if (i == 15) check(outByte == blkBuf[15], "R7", "same-cycle last byte",
                         outByte, blkBuf[15]);
    end
  endtask

  task automatic fillRandom();
    for (int i = 0; i < 16; i++) blkBuf[i] = 8'($urandom);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'($urandom), 8'($urandom));
  endtask

  initial begin
    rstNext = 1'b1;
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 8'h00);
    rstNext = 1'b0;
    tag = "R6";
    tick(1'b0, 1'b0, 8'h00);
    check(outValid == 1'b0, "R6", "outValid after reset", outValid, 0);
    check(outByte == 8'h00, "R6", "outByte after reset", outByte, 0);
    tick(1'b0, 1'b0, 8'h00);

    // R1/R2: a counting block makes the permutation easy to read.
    tag = "R1";
    for (int i = 0; i < 16; i++) blkBuf[i] = 8'(i);
    sendBlock();
    tag = "R8";
    idle(14);

    // R4: back-to-back random blocks.
    tag = "R4";
    for (int n = 0; n < 10; n++) begin
      fillRandom();
      sendBlock();
    end

    // R8 and R5: garbage gaps of lengths that break the 16-cycle rhythm.
    tag = "R8";
    idle(13);
    tag = "R5";
    fillRandom();
    sendBlock();
    tag = "R8";
    idle(21);
    tag = "R5";
    fillRandom();
    sendBlock();
    tag = "R8";
    idle(13);
    tag = "R5";
    for (int n = 0; n < 2; n++) begin
      fillRandom();
      sendBlock();
    end
    tag = "R8";
    idle(30);

    check(expByte.num() == 0, "R3", "undelivered bytes", expByte.num(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule